// File: doc/BRIEF.md
# Two-Wire Auto-Incrementing Register Slave

This block is a byte-oriented two-wire serial slave in front of a bank of 16-bit registers. Both bus lines are open-drain. The block samples the line levels and has pull-low enables as its only bus outputs, so it never drives a line high. The block oversamples both lines with its system clock. It detects START and STOP conditions, matches a fixed 7-bit device address and acknowledges the address byte and every written data byte.

Nothing on the bus carries a register sub-address. A write always begins at the upper byte of register 02h. A read always begins at the upper byte of register 0Ah. From there an internal byte pointer steps upper byte then lower byte through the bank, and after the last register it wraps to register 00h. A register word is committed only when its lower byte arrives. Each commit is shown for one clock on a commit port, so the surrounding logic can follow writes.

Top module: `twr_slave`

## Requirements
- R1: While reset is held and right after it is released, neither line is pulled low and the commit strobe is low.
- R2: A falling SDA while SCL is high (START) starts a new address phase from any state. A rising SDA while SCL is high (STOP) ends the transaction.
- R3: The address byte is shifted in MSB first on SCL rising edges. Its upper seven bits are the device address (default 0010000b) and its last bit is read (1) or write (0). On a match the slave pulls SDA low from the next SCL falling edge until the following SCL falling edge.
- R4: After an address that does not match, the slave gives no acknowledge, pulls no line and commits nothing until the next START.
- R5: During a write, every data byte is acknowledged in the same way as the address byte.
- R6: A write fills register 02h first, upper byte (bits 15:8) before lower byte (bits 7:0), then the following registers in ascending order.
- R7: A register is committed only after both of its bytes have arrived. A commit raises the commit strobe for one clock together with the register index and the 16-bit word. An upper byte that has no lower byte never commits.
- R8: After the lower byte of the last register (15), the pointer wraps to the upper byte of register 00h.
- R9: A read sends bytes MSB first, starting at the upper byte of register 0Ah. The slave changes SDA only while SCL is low. After reset, register n holds its 4-bit index repeated four times (register 5 = 5555h).
- R10: During a read the slave keeps sending bytes, with the same wrap, while the host acknowledges. After a host non-acknowledge it releases SDA until the next START.
- R11: Every STOP resets the pointer, so the next write starts again at the upper byte of register 02h.
- R12: SCL is never pulled low. SDA is only ever pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull_o | output | 1 | Pull SCL low (held inactive) |
| sda_pull_o | output | 1 | Pull SDA low |
| cmt_valid_o | output | 1 | One-clock strobe for a committed register |
| cmt_index_o | output | 4 | Index of the committed register |
| cmt_data_o | output | 16 | Word written to that register |

## Verification
The bench aims at the pointer corners. A second transaction after STOP must land on register 02h again; a design that kept the pointer would write register 04h. An odd-length write must drop its trailing upper byte; a design that committed early would show a spurious commit. A 30-byte write must wrap from register 15 to register 00h; a design with the wrong wrap would write outside the bank or back to 02h. A 34-byte read must wrap the same way and release SDA after the NACK; a design that kept driving would corrupt the STOP. A mismatched address followed by data checks that the slave stays silent and commits nothing.

// File: rtl/twr_pkg.sv
package twr_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 16;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_AACK,
      PH_WDATA,
      PH_WACK,
      PH_RDATA,
      PH_RACK,
      PH_QUIET
   } phase_t;

   // power-on content of register n: its 4-bit index repeated
   function automatic logic [WORD_W-1:0] reg_init(input int unsigned idx);
      logic [3:0] d;
      d = 4'(idx);
      return {d, d, d, d};
   endfunction

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic lvl_o,
   output logic rise_o,
   output logic fall_o
);
   localparam int unsigned DEPTH = STAGES + 1;

   logic [DEPTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;   // released bus idles high
      else        chain <= {chain[DEPTH-2:0], line_i};
   end

   assign lvl_o  = chain[DEPTH-2];
   assign rise_o = chain[DEPTH-2] & ~chain[DEPTH-1];
   assign fall_o = ~chain[DEPTH-2] & chain[DEPTH-1];

endmodule

// File: rtl/twr_byte_ptr.sv
module twr_byte_ptr #(
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned IW = $clog2(NUM_REGS),
   localparam int unsigned PW = IW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [PW-1:0] load_val_i,
   input  logic          adv_i,
   input  logic [PW-1:0] reset_val_i,
   output logic [PW-1:0] ptr_o
);
   localparam int unsigned LAST = 2 * NUM_REGS - 1;

   logic [PW-1:0] nxt;

   generate
      if ((NUM_REGS & (NUM_REGS - 1)) == 0) begin : g_pow2
         assign nxt = ptr_o + PW'(1);
      end else begin : g_mod
         assign nxt = (ptr_o == PW'(LAST)) ? '0 : ptr_o + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= reset_val_i;
      else if (load_i) ptr_o <= load_val_i;
      else if (adv_i)  ptr_o <= nxt;
   end

endmodule

// File: rtl/twr_bank.sv
module twr_bank #(
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned IW = $clog2(NUM_REGS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  logic [IW-1:0] wr_idx_i,
   input  logic [15:0]   wr_data_i,
   input  logic [IW-1:0] rd_idx_i,
   output logic [15:0]   rd_data_o
);
   import twr_pkg::*;

   logic [15:0] regs [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= reg_init(g);
            else if (wr_i && wr_idx_i == IW'(g))
               regs[g] <= wr_data_i;
         end
      end
   endgenerate

   assign rd_data_o = regs[rd_idx_i];

endmodule

// File: rtl/twr_slave.sv
module twr_slave #(
   parameter logic [6:0]  DEV_ADDR     = 7'b0010000,
   parameter int unsigned NUM_REGS     = 16,
   parameter int unsigned WR_START_REG = 2,
   parameter int unsigned RD_START_REG = 10,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        scl_pull_o,
   output logic        sda_pull_o,
   output logic        cmt_valid_o,
   output logic [3:0]  cmt_index_o,
   output logic [15:0] cmt_data_o
);
   import twr_pkg::*;

   localparam int unsigned IW = $clog2(NUM_REGS);
   localparam int unsigned PW = IW + 1;
   localparam logic [PW-1:0] WR_PTR = PW'(2 * WR_START_REG);
   localparam logic [PW-1:0] RD_PTR = PW'(2 * RD_START_REG);

   generate
      if (NUM_REGS < 2 || NUM_REGS > 16) begin : g_bad_regs
         $error("NUM_REGS must be 2..16 to fit the commit index");
      end
      if (WR_START_REG >= NUM_REGS || RD_START_REG >= NUM_REGS) begin : g_bad_start
         $error("start registers must lie inside the bank");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   // line conditioning
   logic [1:0] lin, lvl, rise, fall;
   assign lin = {sda_i, scl_i};

   generate
      for (genvar l = 0; l < 2; l++) begin : g_line
         twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk(clk), .rst_n(rst_n), .line_i(lin[l]),
            .lvl_o(lvl[l]), .rise_o(rise[l]), .fall_o(fall[l]));
      end
   endgenerate

   logic scl_h, scl_rise, scl_fall, sda_s, start_ev, stop_ev;
   assign scl_h    = lvl[0];
   assign scl_rise = rise[0];
   assign scl_fall = fall[0];
   assign sda_s    = lvl[1];
   assign start_ev = scl_h & fall[1];
   assign stop_ev  = scl_h & rise[1];

   // protocol state
   phase_t          phase;
   logic [3:0]      bitcnt;
   logic [7:0]      sr;
   logic [7:0]      tx;
   logic [7:0]      hi_q;
   logic            rw_q;
   logic            host_ack;
   logic            sda_pull;
   logic            cmt_v;
   logic [IW-1:0]   cmt_i;
   logic [15:0]     cmt_d;
   logic            quiet;

   // pointer control
   logic [PW-1:0] ptr, ptr_ld_val;
   logic          ptr_ld, ptr_adv, load_tx, addr_done, byte_done, addr_hit;
   logic [15:0]   rd_word;
   logic [7:0]    tx_byte;

   assign addr_hit  = (sr[7:1] == DEV_ADDR);
   assign addr_done = !start_ev && !stop_ev && phase == PH_ADDR  && scl_fall && bitcnt == 4'd8;
   assign byte_done = !start_ev && !stop_ev && phase == PH_WDATA && scl_fall && bitcnt == 4'd8;
   assign load_tx   = !start_ev && !stop_ev && scl_fall &&
                      ((phase == PH_AACK && rw_q) || (phase == PH_RACK && host_ack));
   assign ptr_ld     = stop_ev || (addr_done && addr_hit);
   assign ptr_ld_val = (!stop_ev && sr[0]) ? RD_PTR : WR_PTR;
   assign ptr_adv    = byte_done || load_tx;
   assign tx_byte    = ptr[0] ? rd_word[7:0] : rd_word[15:8];
   assign quiet      = (phase == PH_QUIET);

   twr_byte_ptr #(.NUM_REGS(NUM_REGS)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_i(ptr_ld), .load_val_i(ptr_ld_val),
      .adv_i(ptr_adv), .reset_val_i(WR_PTR),
      .ptr_o(ptr));

   twr_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_i(cmt_v), .wr_idx_i(cmt_i), .wr_data_i(cmt_d),
      .rd_idx_i(ptr[PW-1:1]), .rd_data_o(rd_word));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bitcnt   <= '0;
         sr       <= '0;
         tx       <= '0;
         hi_q     <= '0;
         rw_q     <= 1'b0;
         host_ack <= 1'b0;
         sda_pull <= 1'b0;
         cmt_v    <= 1'b0;
         cmt_i    <= '0;
         cmt_d    <= '0;
      end else begin
         cmt_v <= 1'b0;
         if (start_ev) begin
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
         end else if (stop_ev) begin
            phase    <= PH_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (phase)
               PH_ADDR, PH_WDATA: begin
                  if (scl_rise && bitcnt < 4'd8) begin
                     sr     <= {sr[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end
                  if (addr_done) begin
                     if (addr_hit) begin
                        sda_pull <= 1'b1;
                        rw_q     <= sr[0];
                        phase    <= PH_AACK;
                     end else begin
                        phase    <= PH_QUIET;
                     end
                  end
                  if (byte_done) begin
                     sda_pull <= 1'b1;
                     phase    <= PH_WACK;
                     if (ptr[0]) begin
                        cmt_v <= 1'b1;
                        cmt_i <= ptr[PW-1:1];
                        cmt_d <= {hi_q, sr};
                     end else begin
                        hi_q  <= sr;
                     end
                  end
               end
               PH_AACK, PH_WACK: begin
                  if (load_tx) begin
                     sda_pull <= ~tx_byte[7];
                     tx       <= {tx_byte[6:0], 1'b0};
                     bitcnt   <= 4'd1;
                     phase    <= PH_RDATA;
                  end else if (scl_fall) begin
                     sda_pull <= 1'b0;
                     bitcnt   <= '0;
                     phase    <= PH_WDATA;
                  end
               end
               PH_RDATA: begin
                  if (scl_fall) begin
                     if (bitcnt < 4'd8) begin
                        sda_pull <= ~tx[7];
                        tx       <= {tx[6:0], 1'b0};
                        bitcnt   <= bitcnt + 4'd1;
                     end else begin
                        sda_pull <= 1'b0;
                        phase    <= PH_RACK;
                     end
                  end
               end
               PH_RACK: begin
                  if (scl_rise) host_ack <= ~sda_s;
                  if (load_tx) begin
                     sda_pull <= ~tx_byte[7];
                     tx       <= {tx_byte[6:0], 1'b0};
                     bitcnt   <= 4'd1;
                     phase    <= PH_RDATA;
                  end else if (scl_fall) begin
                     phase    <= PH_QUIET;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign scl_pull_o  = 1'b0;
   assign sda_pull_o  = sda_pull;
   assign cmt_valid_o = cmt_v;
   assign cmt_index_o = 4'(cmt_i);
   assign cmt_data_o  = cmt_d;

endmodule

// File: rtl/twr_slave_chk.sv
module twr_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic scl_pull,
   input logic sda_pull,
   input logic cmt_valid,
   input logic quiet
);

   // R12: the clock line is never pulled
   assert_scl_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !scl_pull);

   // R9: SDA pull changes only while the SCL line is low
   assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull) |-> !scl_i);

   // R7: a commit strobe lasts a single clock
   assert_commit_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmt_valid |=> !cmt_valid);

   // R5: every commit coincides with the start of an acknowledge
   assert_commit_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmt_valid) |-> $rose(sda_pull));

   // R4: an unaddressed slave never pulls SDA
   assert_quiet_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      quiet |-> !sda_pull);

endmodule

bind twr_slave twr_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i),
   .scl_pull(scl_pull_o), .sda_pull(sda_pull_o),
   .cmt_valid(cmt_valid_o), .quiet(quiet));

// File: tb/tb_twr_slave.sv
`timescale 1ns/1ps
module tb_twr_slave;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_scl = 1'b1;
   logic host_sda = 1'b1;
   logic scl_pull, sda_pull, cmt_valid;
   logic [3:0]  cmt_index;
   logic [15:0] cmt_data;

   wire scl_bus = host_scl & ~scl_pull;
   wire sda_bus = host_sda & ~sda_pull;

   always #2 clk = ~clk;   // 250 MHz

   twr_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
      .cmt_valid_o(cmt_valid), .cmt_index_o(cmt_index), .cmt_data_o(cmt_data));

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 0;
   int model [16];
   int exp_idx [$];
   int exp_dat [$];

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one SCL period: set SDA while low, sample it mid-high
   task automatic bit_cycle(input logic val, output logic smp);
      wait_clk(10);
      host_sda = val;
      wait_clk(10);
      host_scl = 1'b1;
      wait_clk(10);
      smp = sda_bus;
      wait_clk(10);
      host_scl = 1'b0;
   endtask

   task automatic do_start();
      host_sda = 1'b1;
      wait_clk(10);
      host_scl = 1'b1;
      wait_clk(10);
      host_sda = 1'b0;
      wait_clk(10);
      host_scl = 1'b0;
   endtask

   task automatic do_stop();
      wait_clk(10);
      host_sda = 1'b0;
      wait_clk(10);
      host_scl = 1'b1;
      wait_clk(10);
      host_sda = 1'b1;
      wait_clk(20);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
      bit_cycle(1'b1, s);
      acked = !s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, s);
         b[i] = s;
      end
      bit_cycle(!give_ack, s);
   endtask

   function automatic logic [7:0] model_byte(input int p);
      int w;
      w = model[(p / 2) % 16];
      return (p % 2 == 0) ? 8'(w >> 8) : 8'(w);
   endfunction

   // commit port compared with the expected queue on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         check(scl_pull == 1'b0, "R12 scl pull", int'(scl_pull), 0);
         if (cmt_valid) begin
            if (exp_idx.size() == 0) begin
               check(1'b0, "R7 unexpected commit", int'(cmt_index), -1);
            end else begin
               int ei, ed;
               ei = exp_idx.pop_front();
               ed = exp_dat.pop_front();
               check(int'(cmt_index) == ei, "R6 commit index", int'(cmt_index), ei);
               check(int'(cmt_data) == ed, "R6 commit data", int'(cmt_data), ed);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         check(1'b0, "watchdog expired", cyc, 0);
         finish_run();
      end
   end

   task automatic expect_commit(input int idx, input int dat);
      exp_idx.push_back(idx);
      exp_dat.push_back(dat);
      model[idx] = dat;
   endtask

   initial begin
      logic ack;
      logic [7:0] rb;
      for (int i = 0; i < 16; i++) model[i] = (i << 12) | (i << 8) | (i << 4) | i;

      // R1 reset state
      wait_clk(5);
      check(sda_pull == 1'b0, "R1 sda pull in reset", int'(sda_pull), 0);
      check(cmt_valid == 1'b0, "R1 commit in reset", int'(cmt_valid), 0);
      rst_n = 1'b1;
      wait_clk(5);
      check(sda_pull == 1'b0 && scl_pull == 1'b0, "R1 pulls after reset",
            int'({scl_pull, sda_pull}), 0);

      // R2 R3 R5 R6: four bytes to registers 2 and 3
      do_start();
      send_byte(8'h20, ack);
      check(ack, "R3 address ack", int'(ack), 1);
      expect_commit(2, 16'hA1B2);
      expect_commit(3, 16'hC3D4);
      send_byte(8'hA1, ack); check(ack, "R5 data ack 0", int'(ack), 1);
      send_byte(8'hB2, ack); check(ack, "R5 data ack 1", int'(ack), 1);
      send_byte(8'hC3, ack); check(ack, "R5 data ack 2", int'(ack), 1);
      send_byte(8'hD4, ack); check(ack, "R5 data ack 3", int'(ack), 1);
      do_stop();
      check(exp_idx.size() == 0, "R6 commits seen", exp_idx.size(), 0);

      // R11 pointer reset by STOP; R7 trailing upper byte dropped
      do_start();
      send_byte(8'h20, ack);
      check(ack, "R2 address ack after STOP", int'(ack), 1);
      expect_commit(2, 16'h1122);
      send_byte(8'h11, ack);
      send_byte(8'h22, ack);
      send_byte(8'h33, ack);
      check(ack, "R5 lone upper byte ack", int'(ack), 1);
      do_stop();
      check(exp_idx.size() == 0, "R11 restart at register 2", exp_idx.size(), 0);

      // R4 foreign address: silent until next START
      do_start();
      send_byte(8'h22, ack);
      check(!ack, "R4 no address ack", int'(ack), 0);
      send_byte(8'h55, ack);
      check(!ack, "R4 no data ack", int'(ack), 0);
      send_byte(8'h66, ack);
      check(!ack, "R4 still silent", int'(ack), 0);
      do_stop();

      // R8 wrap after register 15 to register 0
      do_start();
      send_byte(8'h20, ack);
      for (int j = 0; j < 15; j++)
         expect_commit((2 + j) % 16, ((8'h40 + 2 * j) << 8) | (8'h41 + 2 * j));
      for (int k = 0; k < 30; k++) send_byte(8'(8'h40 + k), ack);
      do_stop();
      check(exp_idx.size() == 0, "R8 wrap commits seen", exp_idx.size(), 0);

      // R9 R10 read from 0Ah, 34 bytes with wrap, NACK on the last
      do_start();
      send_byte(8'h21, ack);
      check(ack, "R3 read address ack", int'(ack), 1);
      for (int n = 0; n < 34; n++) begin
         logic [7:0] eb;
         eb = model_byte(20 + n);
         recv_byte(n != 33, rb);
         if (n < 12) check(rb == eb, "R9 read byte", int'(rb), int'(eb));
         else        check(rb == eb, "R10 read byte after wrap", int'(rb), int'(eb));
      end
      begin
         logic s;
         bit_cycle(1'b1, s);
         check(s == 1'b1 && sda_pull == 1'b0, "R10 released after NACK", int'(s), 1);
      end
      do_stop();

      // R2 a new START after an ignored transaction works again
      do_start();
      send_byte(8'h20, ack);
      check(ack, "R2 START recovers slave", int'(ack), 1);
      do_stop();

      wait_clk(20);
      check(exp_idx.size() == 0, "R7 no pending commits", exp_idx.size(), 0);
      finish_run();
   end

endmodule